// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the pins of a small general-purpose I/O port and turns pin activity into interrupt requests. Each pin has its own configuration: it can look for a rising edge, a falling edge, either edge, a high level or a low level. Edge events are latched in a sticky raw-status bit that software clears by writing ones. Level events are not latched: the status bit follows the pin while the programmed level is present.

Software reaches the block through byte-wide register reads and writes on a simple strobe interface. It configures the sense mode, the polarity and the dual-edge option with three separate registers, enables pins with a fourth, and inspects status either raw or after the enable mask. One combined interrupt line goes high whenever any enabled pin has pending status. The pin inputs must already be synchronized to the block clock.

Top module: `gpio_irq_detect`

Register offsets (byte address, bit n belongs to pin n): 0x404 sense select (1 = level, 0 = edge), 0x408 dual-edge select, 0x40C polarity (1 = high/rising, 0 = low/falling), 0x410 enable, 0x414 raw status (read-only), 0x418 masked status (read-only), 0x41C clear (write-only).

## Requirements
- R1: After reset every configuration register, the raw status, the read data and `irq_o` are 0; reading any offset then returns 0.
- R2: A pin with sense bit 0, dual-edge bit 0 and polarity bit 1 sets its raw-status bit (offset 0x414) on a 0-to-1 change of the pin, one clock after the change is sampled, and the bit stays set after the pin falls again.
- R3: With sense bit 0, dual-edge bit 0 and polarity bit 0 the raw-status bit is set by a 1-to-0 change and not by a 0-to-1 change.
- R4: With sense bit 0 and dual-edge bit 1 both a rising and a falling change set the raw-status bit, whatever the polarity bit holds.
- R5: With sense bit 1 the raw-status bit equals 1 exactly when the pin equals its polarity bit (registered, one clock behind the pin); a clear write has no lasting effect while that level persists.
- R6: A read of 0x418 returns raw status AND the enable register (offset 0x410, 1 = enabled).
- R7: `irq_o` is the OR of all masked-status bits, registered one clock after the status it reflects.
- R8: Writing 1 to bit n of 0x41C clears the latched edge status of pin n, writing 0 leaves it; if a qualifying edge arrives in the same cycle as the clear, the bit stays set.
- R9: The four configuration registers read back what was written at their own offsets; the clear offset and unmapped offsets read 0.
- R10: Writing sense-polarity or dual-edge configuration does not clear edge status that is already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PINS | Synchronized pin values |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The detector is driven with single rising pulses on a rising-edge pin, rising-then-falling pulses on a falling-edge pin, and both directions on a dual-edge pin whose polarity bit would otherwise reject one of them; these separate the three edge selections from each other and show that status is sticky. Held high and low levels on a level-sensed pin, with clears written during the level, tell level following apart from latching. A clear that lands in the same cycle as a fresh edge separates edge-wins from clear-wins priority, and enable masks that include or exclude the pending pin separate raw from masked status and gate the interrupt line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_SENSE = 12'h404;
  localparam logic [REG_AW-1:0] OFS_DUAL  = 12'h408;
  localparam logic [REG_AW-1:0] OFS_POL   = 12'h40C;
  localparam logic [REG_AW-1:0] OFS_EN    = 12'h410;
  localparam logic [REG_AW-1:0] OFS_RAW   = 12'h414;
  localparam logic [REG_AW-1:0] OFS_MASK  = 12'h418;
  localparam logic [REG_AW-1:0] OFS_CLR   = 12'h41C;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0] dual_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] en_o,
  output logic [N_PINS-1:0] clr_o
);

  logic [N_PINS-1:0] wbits;
  assign wbits = wdata[N_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_o <= '0;
      dual_o  <= '0;
      pol_o   <= '0;
      en_o    <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_SENSE)) sense_o <= wbits;
      if (addr == ADDR_W'(OFS_DUAL))  dual_o  <= wbits;
      if (addr == ADDR_W'(OFS_POL))   pol_o   <= wbits;
      if (addr == ADDR_W'(OFS_EN))    en_o    <= wbits;
    end
  end

  // One-cycle clear pulse per pin, seen by the status logic at the same edge.
  always_comb begin
    clr_o = '0;
    if (wr_en && addr == ADDR_W'(OFS_CLR)) clr_o = wbits;
  end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic sense_i,
  input  logic dual_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);

  logic prev_q;
  logic rise, fall, edge_hit, level_hit;

  assign rise      = pin_i & ~prev_q;
  assign fall      = ~pin_i & prev_q;
  assign edge_hit  = dual_i ? (rise | fall) : (pol_i ? rise : fall);
  assign level_hit = ~(pin_i ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      raw_o  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (sense_i) raw_o <= level_hit;
      else         raw_o <= (raw_o & ~clr_i) | edge_hit;  // new edge beats clear
    end
  end

endmodule

// File: rtl/gpio_irq_rdout.sv
module gpio_irq_rdout
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] sense_i,
  input  logic [N_PINS-1:0] dual_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_PINS-1:0] raw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if      (addr == ADDR_W'(OFS_SENSE)) sel[N_PINS-1:0] = sense_i;
    else if (addr == ADDR_W'(OFS_DUAL))  sel[N_PINS-1:0] = dual_i;
    else if (addr == ADDR_W'(OFS_POL))   sel[N_PINS-1:0] = pol_i;
    else if (addr == ADDR_W'(OFS_EN))    sel[N_PINS-1:0] = en_i;
    else if (addr == ADDR_W'(OFS_RAW))   sel[N_PINS-1:0] = raw_i;
    else if (addr == ADDR_W'(OFS_MASK))  sel[N_PINS-1:0] = raw_i & en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= |(raw_i & en_i);
      if (rd_en) rdata_o <= sel;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic [N_PINS-1:0] sense_q, dual_q, pol_q, en_q, clr_p, raw_q;

  gpio_irq_cfg #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sense_o(sense_q), .dual_o(dual_q), .pol_o(pol_q), .en_o(en_q), .clr_o(clr_p)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_irq_pin pin_u (
      .clk(clk), .rst(rst), .pin_i(pin_i[p]),
      .sense_i(sense_q[p]), .dual_i(dual_q[p]), .pol_i(pol_q[p]),
      .clr_i(clr_p[p]), .raw_o(raw_q[p])
    );
  end

  gpio_irq_rdout #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .sense_i(sense_q), .dual_i(dual_q), .pol_i(pol_q), .en_i(en_q), .raw_i(raw_q),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = REG_AW
) (
  input logic              clk,
  input logic              rst,
  input logic [N_PINS-1:0] pin_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] raw_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] sense_q,
  input logic [N_PINS-1:0] pol_q
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq_o == 1'b0 && rdata_o == '0 && raw_q == '0));

  // R2: latched edge status only drops through a clear write
  a_r2_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(OFS_CLR)) |=>
      (($past(raw_q) & ~$past(sense_q) & ~raw_q) == '0));

  // R5: level pins mirror pin == polarity
  a_r5_level_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((((~($past(pin_i) ^ $past(pol_q))) ^ raw_q) & $past(sense_q)) == '0));

  // R7
  a_r7_irq_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(raw_q & en_q))));

  // R9: clear offset reads as zero
  a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_CLR)) |=> (rdata_o == '0));

endmodule

bind gpio_irq_detect gpio_irq_chk #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata_o(rdata_o), .irq_o(irq_o), .raw_q(raw_q), .en_q(en_q),
  .sense_q(sense_q), .pol_q(pol_q)
);

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;

  localparam logic [11:0] A_SENSE = 12'h404, A_DUAL = 12'h408, A_POL = 12'h40C,
                          A_EN = 12'h410, A_RAW = 12'h414, A_MASK = 12'h418,
                          A_CLR = 12'h41C, A_NONE = 12'h420;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_with_pins(input logic [11:0] a, input logic [7:0] d, input logic [7:0] p);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; pins = p;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: push the expected value, then issue the read.
  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1; sb_q.push_back('{e, t});
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  // Monitor: compare each read result against the scoreboard head.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #2;
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard empty rdata actual=%0h expected=none", rdata);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          checks++;
          if (rdata !== it.exp) begin
            fails++;
            $display("FAIL %s rdata actual=%02h expected=%02h", it.tag, rdata, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_SENSE, 8'h00, "R1 sense");
    rd(A_DUAL,  8'h00, "R1 dual");
    rd(A_POL,   8'h00, "R1 pol");
    rd(A_EN,    8'h00, "R1 en");
    rd(A_RAW,   8'h00, "R1 raw");
    rd(A_MASK,  8'h00, "R1 mask");

    // R9 config readback: edge everywhere, pins 0-3 rising, 4-7 falling, 4-5 dual
    wr(A_EN, 8'hFF);  wr(A_POL, 8'h0F); wr(A_DUAL, 8'h30); wr(A_SENSE, 8'h00);
    rd(A_EN,   8'hFF, "R9 en");
    rd(A_POL,  8'h0F, "R9 pol");
    rd(A_DUAL, 8'h30, "R9 dual");
    rd(A_CLR,  8'h00, "R9 clr reads zero");
    rd(A_NONE, 8'h00, "R9 unmapped");

    // R2 rising edge latches, stays after fall
    pins = 8'h01;
    rd(A_RAW, 8'h01, "R2 rise");
    chk_irq(1'b1, "R7 irq on");
    pins = 8'h00;
    rd(A_RAW, 8'h01, "R2 sticky");

    // R8 clear
    wr(A_CLR, 8'h00);
    rd(A_RAW, 8'h01, "R8 write zero");
    wr(A_CLR, 8'h01);
    rd(A_RAW, 8'h00, "R8 write one");
    chk_irq(1'b0, "R7 irq off");

    // R3 falling edge
    pins = 8'h40;
    rd(A_RAW, 8'h00, "R3 rise ignored");
    pins = 8'h00;
    rd(A_RAW, 8'h40, "R3 fall");

    // R4 dual edge on pin 4 (polarity bit 0 would reject the rise)
    wr(A_CLR, 8'hFF);
    pins = 8'h10;
    rd(A_RAW, 8'h10, "R4 rise");
    wr(A_CLR, 8'h10);
    rd(A_RAW, 8'h00, "R4 cleared");
    pins = 8'h00;
    rd(A_RAW, 8'h10, "R4 fall");

    // R6 masking
    wr(A_EN, 8'h01);
    rd(A_MASK, 8'h00, "R6 masked off");
    chk_irq(1'b0, "R7 masked irq");
    wr(A_EN, 8'h10);
    rd(A_MASK, 8'h10, "R6 masked on");
    chk_irq(1'b1, "R7 enabled irq");

    // R10 config change keeps latched status
    wr(A_POL, 8'hFF);
    wr(A_DUAL, 8'h00);
    rd(A_RAW, 8'h10, "R10 kept");

    // R8 clear vs same-cycle edge on pin 1
    wr(A_CLR, 8'hFF);
    rd(A_RAW, 8'h00, "R8 all clear");
    wr_with_pins(A_CLR, 8'h02, 8'h02);
    rd(A_RAW, 8'h02, "R8 edge wins");

    // R5 level sensing on pin 7
    wr(A_CLR, 8'hFF);
    wr(A_SENSE, 8'h80);
    rd(A_RAW, 8'h00, "R5 high level absent");
    pins = 8'h82;
    rd(A_RAW, 8'h80, "R5 high level");
    wr(A_CLR, 8'h80);
    rd(A_RAW, 8'h80, "R5 clear no effect");
    pins = 8'h02;
    rd(A_RAW, 8'h00, "R5 level gone");
    wr(A_POL, 8'h7F);
    rd(A_RAW, 8'h80, "R5 low level");
    wr(A_EN, 8'h80);
    rd(A_MASK, 8'h80, "R6 level masked");
    chk_irq(1'b1, "R7 level irq");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule